// File: doc/BRIEF.md
# Virtual-Channel ADC Scan Sequencer

This block sequences a single analog-to-digital conversion unit through programmable conversion lists. A table of virtual channels gives each entry a physical input index. Scan groups are defined as contiguous ranges of that table, and each group has a priority. When a group is triggered, the sequencer requests one conversion per virtual channel of the group, in ascending index order. Each 12-bit result is stored in the result register that belongs to the virtual channel, not the physical input. A physical input can therefore appear in several entries, and every appearance keeps its own result. The last conversion of a group raises a one-cycle interrupt on that group's line.

Several groups may be pending at once. The sequencer serves them one at a time. Between groups it picks the pending group with the largest priority value, and when priorities are equal it picks the lowest group number. A group that is already converting runs to its end even if a more urgent group is triggered meanwhile. A trigger that arrives for a group that is already pending or running is reported on an overrun line and otherwise has no effect.

The converter sits outside the block. It sees a one-cycle start pulse with a 5-bit physical index and answers with a done pulse that carries the 12-bit sample.

Top module: `adc_scan_sequencer`

## Requirements
- R1: After reset, conv_start, grp_irq and grp_ovr are 0, and every result register reads 0.
- R2: Each conversion request drives conv_phys with the 5-bit physical index that is configured for the virtual channel being converted. Any physical index may be configured in several virtual channels.
- R3: A triggered group with first index F and last index L (F <= L) issues exactly L-F+1 requests, for virtual channels F, F+1, ... L in that order. No new request is issued while an earlier one has not yet received conv_done.
- R4: The conv_data that accompanies conv_done is stored in the result register of the virtual channel being converted. It can be read on rd_data by placing that channel's index on rd_vch. Results persist until overwritten.
- R5: grp_irq bit g pulses for exactly one cycle, in the cycle after the conv_done of group g's last conversion. At most one bit is high at a time.
- R6: Among pending groups, the next group served is the one with the largest 3-bit priority value. When priorities are equal, the lower group number is served first.
- R7: A group that has started converting is never interrupted. Groups triggered during its run wait until it finishes.
- R8: A trigger for a group that is already pending or running produces a one-cycle pulse on grp_ovr bit g in the following cycle. It adds no conversion and no completion.
- R9: A group configured with last index below first index converts only its first virtual channel and then completes.
- R10: conv_start is a single-cycle pulse, and conv_phys stays constant until the matching conv_done. A conv_done that arrives while no request is outstanding writes no result and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vt_we | input | 1 | Write strobe for the virtual-channel table |
| vt_idx | input | 7 | Virtual channel being written |
| vt_phys | input | 5 | Physical input index for that virtual channel |
| gc_we | input | 1 | Write strobe for a group definition |
| gc_idx | input | 4 | Group being written |
| gc_first | input | 7 | First virtual channel of the group |
| gc_last | input | 7 | Last virtual channel of the group |
| gc_prio | input | 3 | Group priority, larger value is more urgent |
| trig | input | 10 | One trigger bit per group |
| conv_start | output | 1 | Conversion request pulse |
| conv_phys | output | 5 | Physical input to convert |
| conv_done | input | 1 | Conversion finished pulse |
| conv_data | input | 12 | Converted sample, valid with conv_done |
| rd_vch | input | 7 | Virtual channel whose result is shown |
| rd_data | output | 12 | Result register of rd_vch |
| grp_irq | output | 10 | Per-group completion pulse |
| grp_ovr | output | 10 | Per-group trigger overrun pulse |

## Verification
The hardest situations to reach from the ports depend on when a trigger lands relative to the edge at which a group is taken. A repeated trigger must hit once while the group is still only pending and once while it is already converting. A more urgent group must arrive after a less urgent one has been taken but before that group finishes. The bench reaches these cases by driving trigger masks on consecutive cycles from a known idle state, so the first mask is always taken on a known edge and the later masks land inside the run. Randomised tables with overlapping ranges, repeated physical inputs and reversed ranges then check the served order, the request sequence and all result registers against a bench model.

// File: rtl/adcs_pkg.sv
package adcs_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_e;

  // a group ends when the current entry reaches or passes its last entry;
  // this also makes a reversed range stop after its first entry
  function automatic logic is_final(input int unsigned cur, input int unsigned last);
    return cur >= last;
  endfunction

endpackage

// File: rtl/adcs_cfg_store.sv
module adcs_cfg_store #(
  parameter int NUM_VCH = 72,
  parameter int NUM_GRP = 10,
  parameter int PHYS_W  = 5,
  parameter int PRIO_W  = 3,
  localparam int VCH_W  = $clog2(NUM_VCH),
  localparam int GRP_W  = $clog2(NUM_GRP)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      vt_we,
  input  logic [VCH_W-1:0]          vt_idx,
  input  logic [PHYS_W-1:0]         vt_phys,
  input  logic                      gc_we,
  input  logic [GRP_W-1:0]          gc_idx,
  input  logic [VCH_W-1:0]          gc_first,
  input  logic [VCH_W-1:0]          gc_last,
  input  logic [PRIO_W-1:0]         gc_prio,
  input  logic [VCH_W-1:0]          rd_vch,
  output logic [PHYS_W-1:0]         rd_phys,
  input  logic [GRP_W-1:0]          sel_grp,
  output logic [VCH_W-1:0]          sel_first,
  output logic [VCH_W-1:0]          sel_last,
  output logic [NUM_GRP*PRIO_W-1:0] prio_flat
);
  localparam logic [VCH_W:0] NV_L = NUM_VCH[VCH_W:0];
  localparam logic [GRP_W:0] NG_L = NUM_GRP[GRP_W:0];

  logic [PHYS_W-1:0] phys_q  [NUM_VCH];
  logic [VCH_W-1:0]  first_q [NUM_GRP];
  logic [VCH_W-1:0]  last_q  [NUM_GRP];
  logic [PRIO_W-1:0] prio_q  [NUM_GRP];

  logic vt_ok, gc_ok, rd_ok, sel_ok;
  assign vt_ok  = {1'b0, vt_idx} < NV_L;
  assign gc_ok  = ({1'b0, gc_idx} < NG_L) && ({1'b0, gc_first} < NV_L) && ({1'b0, gc_last} < NV_L);
  assign rd_ok  = {1'b0, rd_vch} < NV_L;
  assign sel_ok = {1'b0, sel_grp} < NG_L;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < NUM_VCH; v++) phys_q[v] <= '0;
      for (int g = 0; g < NUM_GRP; g++) begin
        first_q[g] <= '0;
        last_q[g]  <= '0;
        prio_q[g]  <= '0;
      end
    end else begin
      if (vt_we && vt_ok) phys_q[vt_idx] <= vt_phys;
      if (gc_we && gc_ok) begin
        first_q[gc_idx] <= gc_first;
        last_q[gc_idx]  <= gc_last;
        prio_q[gc_idx]  <= gc_prio;
      end
    end
  end

  assign rd_phys   = rd_ok  ? phys_q[rd_vch]   : '0;
  assign sel_first = sel_ok ? first_q[sel_grp] : '0;
  assign sel_last  = sel_ok ? last_q[sel_grp]  : '0;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_prio
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
  end

endmodule

// File: rtl/adcs_arbiter.sv
module adcs_arbiter #(
  parameter int NUM_GRP = 10,
  parameter int PRIO_W  = 3,
  localparam int GRP_W  = $clog2(NUM_GRP)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_GRP-1:0]        trig,
  input  logic [NUM_GRP*PRIO_W-1:0] prio_flat,
  input  logic                      take,
  input  logic [GRP_W-1:0]          take_idx,
  input  logic                      run_active,
  input  logic [GRP_W-1:0]          run_grp,
  output logic [NUM_GRP-1:0]        ovr,
  output logic                      pick_valid,
  output logic [GRP_W-1:0]          pick_idx
);
  logic [NUM_GRP-1:0] pend_q, busy, clr;
  logic [PRIO_W-1:0]  best;

  always_comb begin
    for (int g = 0; g < NUM_GRP; g++) begin
      busy[g] = pend_q[g] | (run_active && (run_grp == GRP_W'(g)));
      clr[g]  = take && (take_idx == GRP_W'(g));
    end
  end

  // strict comparison keeps the lower group number on equal priority
  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = '0;
    best       = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (pend_q[g] && (!pick_valid || (prio_flat[g*PRIO_W +: PRIO_W] > best))) begin
        pick_valid = 1'b1;
        pick_idx   = GRP_W'(g);
        best       = prio_flat[g*PRIO_W +: PRIO_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ovr    <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | (trig & ~busy);
      ovr    <= trig & busy;
    end
  end

endmodule

// File: rtl/adcs_result_bank.sv
module adcs_result_bank #(
  parameter int NUM_VCH = 72,
  parameter int DATA_W  = 12,
  localparam int VCH_W  = $clog2(NUM_VCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [VCH_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [VCH_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [VCH_W:0] NV_L = NUM_VCH[VCH_W:0];

  logic [DATA_W-1:0] res_q [NUM_VCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < NUM_VCH; v++) res_q[v] <= '0;
    end else if (we && ({1'b0, waddr} < NV_L)) begin
      res_q[waddr] <= wdata;
    end
  end

  assign rdata = ({1'b0, raddr} < NV_L) ? res_q[raddr] : '0;

endmodule

// File: rtl/adcs_sequencer.sv
module adcs_sequencer
  import adcs_pkg::*;
#(
  parameter int NUM_VCH = 72,
  parameter int NUM_GRP = 10,
  parameter int PHYS_W  = 5,
  parameter int DATA_W  = 12,
  localparam int VCH_W  = $clog2(NUM_VCH),
  localparam int GRP_W  = $clog2(NUM_GRP)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pick_valid,
  input  logic [GRP_W-1:0]   pick_idx,
  output logic [GRP_W-1:0]   sel_grp,
  input  logic [VCH_W-1:0]   sel_first,
  input  logic [VCH_W-1:0]   sel_last,
  output logic [VCH_W-1:0]   tab_vch,
  input  logic [PHYS_W-1:0]  tab_phys,
  output logic               take,
  output logic               run_active,
  output logic [GRP_W-1:0]   run_grp,
  output logic               conv_start,
  output logic [PHYS_W-1:0]  conv_phys,
  input  logic               conv_done,
  input  logic [DATA_W-1:0]  conv_data,
  output logic               res_we,
  output logic [VCH_W-1:0]   res_addr,
  output logic [DATA_W-1:0]  res_data,
  output logic [NUM_GRP-1:0] irq,
  output logic               waiting,
  output logic               finish
);
  sq_state_e          st_q;
  logic [GRP_W-1:0]   grp_q;
  logic [VCH_W-1:0]   vch_q, last_q;
  logic [PHYS_W-1:0]  phys_q;
  logic [NUM_GRP-1:0] irq_q, grp_hot;
  logic               at_end;

  assign at_end  = is_final(32'(vch_q), 32'(last_q));
  assign take    = (st_q == SQ_IDLE) && pick_valid;
  assign sel_grp = pick_idx;
  assign tab_vch = (st_q == SQ_IDLE) ? sel_first : vch_q + 1'b1;

  always_comb begin
    for (int g = 0; g < NUM_GRP; g++) grp_hot[g] = (grp_q == GRP_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      grp_q  <= '0;
      vch_q  <= '0;
      last_q <= '0;
      phys_q <= '0;
      irq_q  <= '0;
    end else begin
      irq_q <= '0;
      case (st_q)
        SQ_IDLE: if (pick_valid) begin
          grp_q  <= pick_idx;
          vch_q  <= sel_first;
          last_q <= sel_last;
          phys_q <= tab_phys;
          st_q   <= SQ_REQ;
        end
        SQ_REQ: st_q <= SQ_WAIT;
        SQ_WAIT: if (conv_done) begin
          if (at_end) begin
            irq_q <= grp_hot;
            st_q  <= SQ_IDLE;
          end else begin
            vch_q  <= vch_q + 1'b1;
            phys_q <= tab_phys;
            st_q   <= SQ_REQ;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign conv_start = (st_q == SQ_REQ);
  assign conv_phys  = phys_q;
  assign waiting    = (st_q == SQ_WAIT);
  assign res_we     = waiting && conv_done;
  assign res_addr   = vch_q;
  assign res_data   = conv_data;
  assign finish     = res_we && at_end;
  assign run_active = (st_q != SQ_IDLE);
  assign run_grp    = grp_q;
  assign irq        = irq_q;

endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer #(
  parameter int NUM_VCH = 72,
  parameter int NUM_GRP = 10,
  parameter int PHYS_W  = 5,
  parameter int DATA_W  = 12,
  parameter int PRIO_W  = 3,
  localparam int VCH_W  = $clog2(NUM_VCH),
  localparam int GRP_W  = $clog2(NUM_GRP)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vt_we,
  input  logic [VCH_W-1:0]   vt_idx,
  input  logic [PHYS_W-1:0]  vt_phys,
  input  logic               gc_we,
  input  logic [GRP_W-1:0]   gc_idx,
  input  logic [VCH_W-1:0]   gc_first,
  input  logic [VCH_W-1:0]   gc_last,
  input  logic [PRIO_W-1:0]  gc_prio,
  input  logic [NUM_GRP-1:0] trig,
  output logic               conv_start,
  output logic [PHYS_W-1:0]  conv_phys,
  input  logic               conv_done,
  input  logic [DATA_W-1:0]  conv_data,
  input  logic [VCH_W-1:0]   rd_vch,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NUM_GRP-1:0] grp_irq,
  output logic [NUM_GRP-1:0] grp_ovr
);
  logic [NUM_GRP*PRIO_W-1:0] prio_flat;
  logic [GRP_W-1:0]  sel_grp, pick_idx;
  logic [VCH_W-1:0]  sel_first, sel_last, tab_vch, res_addr;
  logic [PHYS_W-1:0] tab_phys;
  logic [DATA_W-1:0] res_data;
  logic              pick_valid, take, res_we;

  // named internal events for the checker
  logic              seq_active, seq_waiting, seq_finish;
  logic [GRP_W-1:0]  seq_grp;

  adcs_cfg_store #(.NUM_VCH(NUM_VCH), .NUM_GRP(NUM_GRP), .PHYS_W(PHYS_W), .PRIO_W(PRIO_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .vt_we(vt_we), .vt_idx(vt_idx), .vt_phys(vt_phys),
    .gc_we(gc_we), .gc_idx(gc_idx), .gc_first(gc_first), .gc_last(gc_last), .gc_prio(gc_prio),
    .rd_vch(tab_vch), .rd_phys(tab_phys),
    .sel_grp(sel_grp), .sel_first(sel_first), .sel_last(sel_last),
    .prio_flat(prio_flat)
  );

  adcs_arbiter #(.NUM_GRP(NUM_GRP), .PRIO_W(PRIO_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .trig(trig), .prio_flat(prio_flat),
    .take(take), .take_idx(pick_idx),
    .run_active(seq_active), .run_grp(seq_grp),
    .ovr(grp_ovr), .pick_valid(pick_valid), .pick_idx(pick_idx)
  );

  adcs_sequencer #(.NUM_VCH(NUM_VCH), .NUM_GRP(NUM_GRP), .PHYS_W(PHYS_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .pick_valid(pick_valid), .pick_idx(pick_idx),
    .sel_grp(sel_grp), .sel_first(sel_first), .sel_last(sel_last),
    .tab_vch(tab_vch), .tab_phys(tab_phys),
    .take(take), .run_active(seq_active), .run_grp(seq_grp),
    .conv_start(conv_start), .conv_phys(conv_phys),
    .conv_done(conv_done), .conv_data(conv_data),
    .res_we(res_we), .res_addr(res_addr), .res_data(res_data),
    .irq(grp_irq), .waiting(seq_waiting), .finish(seq_finish)
  );

  adcs_result_bank #(.NUM_VCH(NUM_VCH), .DATA_W(DATA_W)) u_res (
    .clk(clk), .rst_n(rst_n),
    .we(res_we), .waddr(res_addr), .wdata(res_data),
    .raddr(rd_vch), .rdata(rd_data)
  );

endmodule

// File: rtl/adcs_checker.sv
module adcs_checker #(
  parameter int NUM_GRP = 10,
  parameter int PHYS_W  = 5,
  parameter int GRP_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_GRP-1:0] trig,
  input logic               conv_start,
  input logic [PHYS_W-1:0]  conv_phys,
  input logic               conv_done,
  input logic [NUM_GRP-1:0] grp_irq,
  input logic [NUM_GRP-1:0] grp_ovr,
  input logic               seq_waiting,
  input logic               seq_active,
  input logic               seq_finish,
  input logic [GRP_W-1:0]   seq_grp
);
  // R10
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R10
  phys_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_waiting && !conv_done) |=> $stable(conv_phys));

  // R3
  no_early_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_waiting && !conv_done) |=> !conv_start);

  // R5
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_irq));

  // R5
  irq_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_finish |=> (grp_irq != '0));

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_irq != '0) |-> $past(conv_done));

  // R8
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_ovr != '0) |-> ((grp_ovr & ~$past(trig)) == '0));

  // R7
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && $past(seq_active)) |-> $stable(seq_grp));

endmodule

bind adc_scan_sequencer adcs_checker #(.NUM_GRP(NUM_GRP), .PHYS_W(PHYS_W), .GRP_W(GRP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig),
  .conv_start(conv_start), .conv_phys(conv_phys), .conv_done(conv_done),
  .grp_irq(grp_irq), .grp_ovr(grp_ovr),
  .seq_waiting(seq_waiting), .seq_active(seq_active),
  .seq_finish(seq_finish), .seq_grp(seq_grp)
);

// File: tb/adc_scan_sequencer_test.sv
module adc_scan_sequencer_test;
  localparam int NV = 72, NG = 10, PW = 5, DW = 12, RW = 3, VW = 7, GW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          vt_we = 0, gc_we = 0;
  logic [VW-1:0] vt_idx = '0, gc_first = '0, gc_last = '0, rd_vch = '0;
  logic [PW-1:0] vt_phys = '0;
  logic [GW-1:0] gc_idx = '0;
  logic [RW-1:0] gc_prio = '0;
  logic [NG-1:0] trig = '0;
  logic          conv_start, conv_done;
  logic [PW-1:0] conv_phys;
  logic [DW-1:0] conv_data, rd_data;
  logic [NG-1:0] grp_irq, grp_ovr;

  adc_scan_sequencer uut (
    .clk(clk), .rst_n(rst_n),
    .vt_we(vt_we), .vt_idx(vt_idx), .vt_phys(vt_phys),
    .gc_we(gc_we), .gc_idx(gc_idx), .gc_first(gc_first), .gc_last(gc_last), .gc_prio(gc_prio),
    .trig(trig), .conv_start(conv_start), .conv_phys(conv_phys),
    .conv_done(conv_done), .conv_data(conv_data),
    .rd_vch(rd_vch), .rd_data(rd_data), .grp_irq(grp_irq), .grp_ovr(grp_ovr)
  );

  int checks = 0, fails = 0, cyc = 0;
  int tb_phys [NV];
  int exp_res [NV];
  int tb_gs [NG], tb_ge [NG], tb_pr [NG];
  int log_phys [4096];
  int log_n = 0;
  int irq_log [1024];
  int irq_n = 0;
  int ovr_cnt [NG];
  int irq_bad = 0;
  int exp_ord [NG];
  int exp_n = 0;

  function automatic int mkdata(input int p, input int k);
    return (p * 37 + k * 113 + 5) % 4096;
  endfunction

  // bench order rule: scan downward so ties settle on the lower group number
  function automatic int pick(input logic [NG-1:0] m);
    int b = -1;
    for (int g = NG - 1; g >= 0; g--)
      if (m[g] && (b < 0 || tb_pr[g] >= tb_pr[b])) b = g;
    return b;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // converter model
  logic    cm_busy = 0, cm_done = 0, spur_done = 0;
  int      cm_wait = 0, cm_phys = 0, cm_k = 0;
  logic [DW-1:0] cm_data = '0;
  assign conv_done = cm_done | spur_done;
  assign conv_data = spur_done ? 12'hA5C : cm_data;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      cm_busy <= 0; cm_done <= 0; cm_wait <= 0;
    end else begin
      cm_done <= 1'b0;
      if (cm_busy) begin
        if (cm_wait == 0) begin
          cm_done <= 1'b1;
          cm_data <= DW'(mkdata(cm_phys, cm_k));
          cm_busy <= 1'b0;
        end else cm_wait <= cm_wait - 1;
      end else if (conv_start) begin
        cm_busy <= 1'b1;
        cm_wait <= int'($urandom % 3);
        cm_phys <= int'(conv_phys);
        cm_k    <= log_n;
        if (log_n < 4096) log_phys[log_n] = int'(conv_phys);
        log_n = log_n + 1;
      end
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (grp_irq != '0 && !conv_done) irq_bad = irq_bad + 1;
      for (int g = 0; g < NG; g++) begin
        if (grp_irq[g]) begin
          if (irq_n < 1024) irq_log[irq_n] = g;
          irq_n = irq_n + 1;
        end
        if (grp_ovr[g]) ovr_cnt[g] = ovr_cnt[g] + 1;
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic set_vch(input int v, input int p);
    @(negedge clk);
    vt_we = 1; vt_idx = VW'(v); vt_phys = PW'(p);
    @(negedge clk);
    vt_we = 0;
    tb_phys[v] = p;
  endtask

  task automatic set_grp(input int g, input int f, input int l, input int p);
    @(negedge clk);
    gc_we = 1; gc_idx = GW'(g); gc_first = VW'(f); gc_last = VW'(l); gc_prio = RW'(p);
    @(negedge clk);
    gc_we = 0;
    tb_gs[g] = f; tb_ge[g] = l; tb_pr[g] = p;
  endtask

  task automatic count_result_errors(output int bad);
    bad = 0;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      rd_vch = VW'(v);
      #1;
      if (rd_data !== DW'(exp_res[v])) bad++;
    end
  endtask

  // first is taken on a known edge; later lands while it runs
  task automatic do_round(input logic [NG-1:0] first, input logic [NG-1:0] later, input string tag);
    int base_log, base_irq, p, en, bad, lastv;
    logic [NG-1:0] pend;
    int ephys [1024];
    base_log = log_n; base_irq = irq_n; en = 0; exp_n = 0;
    pend = first;
    p = pick(pend); pend[p] = 1'b0; pend = pend | later;
    exp_ord[exp_n++] = p;
    while (pend != '0) begin
      p = pick(pend); pend[p] = 1'b0; exp_ord[exp_n++] = p;
    end
    for (int i = 0; i < exp_n; i++) begin
      lastv = (tb_ge[exp_ord[i]] < tb_gs[exp_ord[i]]) ? tb_gs[exp_ord[i]] : tb_ge[exp_ord[i]];
      for (int v = tb_gs[exp_ord[i]]; v <= lastv; v++) begin
        ephys[en] = tb_phys[v];
        exp_res[v] = mkdata(tb_phys[v], base_log + en);
        en++;
      end
    end
    @(negedge clk); trig = first;
    @(negedge clk); trig = later;
    @(negedge clk); trig = '0;
    for (int t = 0; t < 4000 && irq_n < base_irq + exp_n; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R5", {tag, " completions"}, irq_n - base_irq, exp_n);
    bad = 0;
    for (int i = 0; i < exp_n; i++) if (irq_log[base_irq + i] != exp_ord[i]) bad++;
    chk("R6,R7", {tag, " service order mismatches"}, bad, 0);
    chk("R3", {tag, " conversion count"}, log_n - base_log, en);
    bad = 0;
    for (int i = 0; i < en; i++) if (log_phys[base_log + i] != ephys[i]) bad++;
    chk("R2", {tag, " physical index mismatches"}, bad, 0);
    count_result_errors(bad);
    chk("R4", {tag, " result register mismatches"}, bad, 0);
  endtask

  initial begin
    int unsigned seed_set;
    int b, bad, s, e, l0, i0;
    logic [NG-1:0] fm, lm;
    seed_set = $urandom(32'h1F2E);
    for (int v = 0; v < NV; v++) begin tb_phys[v] = 0; exp_res[v] = 0; end
    for (int g = 0; g < NG; g++) begin tb_gs[g] = 0; tb_ge[g] = 0; tb_pr[g] = 0; ovr_cnt[g] = 0; end

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1", "conv_start after reset", int'(conv_start), 0);
    chk("R1", "grp_irq after reset", int'(grp_irq), 0);
    chk("R1", "grp_ovr after reset", int'(grp_ovr), 0);
    count_result_errors(bad);
    chk("R1", "nonzero results after reset", bad, 0);

    // R2: one physical input in several virtual channels, overlapping groups
    for (int v = 40; v <= 43; v++) set_vch(v, 9);
    set_vch(50, 9);
    set_grp(0, 40, 43, 2);
    set_grp(1, 42, 42, 7);
    set_grp(2, 50, 50, 4);
    do_round(10'b0000000101, 10'b0000000010, "repeated input");

    // R6: equal priority served by lower number, higher value first
    for (int v = 0; v < 12; v++) set_vch(v, v + 3);
    set_grp(4, 0, 1, 5);
    set_grp(7, 2, 3, 5);
    set_grp(8, 4, 5, 6);
    b = irq_n;
    do_round((10'b1 << 4) | (10'b1 << 7) | (10'b1 << 8), '0, "priority tie");
    chk("R6", "first served group", irq_log[b], 8);
    chk("R6", "tie served group", irq_log[b + 1], 4);

    // R7: urgent group triggered during a long low-priority run
    set_grp(6, 6, 10, 0);
    set_grp(9, 11, 11, 7);
    b = irq_n;
    do_round(10'b1 << 6, 10'b1 << 9, "no preemption");
    chk("R7", "running group completes first", irq_log[b], 6);

    // R9: reversed range converts its first entry only
    set_grp(5, 30, 27, 3);
    set_vch(30, 21);
    b = log_n;
    do_round(10'b1 << 5, '0, "reversed range");
    chk("R9", "conversions of reversed group", log_n - b, 1);
    chk("R9", "converted input of reversed group", log_phys[b], 21);

    // R8: retrigger while pending, then while running
    for (int v = 20; v <= 22; v++) set_vch(v, v - 10);
    set_grp(3, 20, 22, 1);
    l0 = log_n; i0 = irq_n;
    for (int v = 20; v <= 22; v++) exp_res[v] = mkdata(tb_phys[v], l0 + v - 20);
    @(negedge clk); trig = 10'b1 << 3;
    @(negedge clk); trig = 10'b1 << 3;
    @(negedge clk); trig = 10'b1 << 3;
    @(negedge clk); trig = '0;
    for (int t = 0; t < 4000 && irq_n < i0 + 1; t++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R8", "overrun pulses", ovr_cnt[3], 2);
    chk("R8", "completions after retriggers", irq_n - i0, 1);
    chk("R8", "conversions after retriggers", log_n - l0, 3);
    count_result_errors(bad);
    chk("R4", "results after overrun test", bad, 0);

    // R10: stray done while idle is ignored
    l0 = log_n; i0 = irq_n;
    @(negedge clk); spur_done <= 1'b1;
    @(negedge clk); spur_done <= 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "interrupts from stray done", irq_n - i0, 0);
    count_result_errors(bad);
    chk("R10", "results changed by stray done", bad, 0);

    // randomized tables and trigger patterns
    for (int r = 0; r < 20; r++) begin
      for (int v = 0; v < NV; v++) set_vch(v, int'($urandom % 32));
      for (int g = 0; g < NG; g++) begin
        s = int'($urandom % NV);
        e = s + int'($urandom % 4);
        if (e > NV - 1) e = NV - 1;
        if (($urandom % 8) == 0 && s > 0) e = s - 1;
        set_grp(g, s, e, int'($urandom % 8));
      end
      fm = NG'($urandom % 1024);
      if (fm == '0) fm = 10'b1;
      lm = (($urandom % 2) == 0) ? '0 : (NG'($urandom % 1024) & ~fm);
      do_round(fm, lm, "random");
    end

    b = 0;
    for (int g = 0; g < NG; g++) b += ovr_cnt[g];
    chk("R8", "total overruns over whole run", b, 2);
    chk("R5", "interrupts not following a done", irq_bad, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule